// File: doc/BRIEF.md
# Bandwidth Gap Link Scheduler

This block decides which virtual link may put its next frame on the wire. Each link is held to at most one frame per bandwidth gap, a power-of-two number of milliseconds chosen per link. A link can be split into two to four sub-queues that take turns in round-robin order, so each sub-queue keeps its own frames in arrival order while sharing the link's single slot per gap.

The block counts a one-cycle millisecond tick, reads a gap selection and a sub-queue count for each link, and watches one "frame waiting" flag per sub-queue. When a link's gap has expired and one of its active sub-queues has a frame, the block raises a grant naming the link, the sub-queue and the 8-bit sequence number the frame must carry. Only one grant is outstanding at a time; the transmitter releases it with a one-cycle done pulse. The gap timer restarts at the grant, and a link whose gap expired while it was idle is granted as soon as a frame appears.

Top module: `gap_link_sched`

## Requirements
- R1: After reset `grant_valid` is 0, every link's gap is already open, and the first grant of each link carries sequence number 0.
- R2: The gap of link l is 2^s ms, with s = `cfg_gap_sel[3l+2:3l]`. After a grant of link l, that link is not granted again until 2^s rising clock edges with `ms_tick` high have passed; the gap opens at the edge that counts the last of these ticks and, with a frame waiting, the grant is raised at the following edge.
- R3: A link whose gap expired while none of its sub-queues had a frame is granted at the first clock edge at which a frame flag of an active sub-queue is high.
- R4: When several links are eligible at the same edge, the link with the lowest index is granted.
- R5: At most one grant is outstanding. `grant_valid`, `grant_link`, `grant_subq` and `grant_seq` hold steady until `tx_done` is sampled high, and `grant_valid` falls at that same edge; no new grant is raised at that edge.
- R6: With a sub-queue count n = `cfg_subq[3l+2:3l]` of 2, 3 or 4 (values above 4 act as 4), sub-queues 0 to n-1 of link l are served round-robin: the search starts at the sub-queue after the last one granted, skipping empty ones; flags of sub-queues at or above n are ignored.
- R7: A sub-queue count of 0 or 1 disables sub-queues: only sub-queue 0 of that link is served and the other flags of the link are ignored.
- R8: Each link has its own sequence number that advances by one per grant of that link; after 255 the next value is 1, never 0.
- R9: A grant is only raised for a sub-queue whose flag, `queue_ready[4l+q]`, was high at the edge that raised it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| cfg_gap_sel | input | 3*NUM_LINKS | Per-link gap exponent, gap = 2^value ms |
| cfg_subq | input | 3*NUM_LINKS | Per-link sub-queue count (0/1 off, 2..4) |
| queue_ready | input | MAX_SUBQ*NUM_LINKS | Frame-waiting flag per sub-queue, bit MAX_SUBQ*link+subq |
| tx_done | input | 1 | Transmitter has finished the granted frame |
| grant_valid | output | 1 | A grant is outstanding |
| grant_link | output | clog2(NUM_LINKS) | Granted link index |
| grant_subq | output | clog2(MAX_SUBQ) | Granted sub-queue index |
| grant_seq | output | 8 | Sequence number to append to the frame |

## Verification
The assertions watch, on every cycle, that an outstanding grant stays frozen until the done pulse and vanishes right after it, that a new grant names a sub-queue whose flag was set, and that the granted sub-queue lies inside the link's configured count. Gap timing, lowest-index priority, the round-robin order across several grants, the immediate grant after an idle expiry and the 255-to-1 sequence wrap span many grants and ticks, so only the bench's directed scenarios show them.

// File: rtl/gls_pkg.sv
// Shared widths and helpers for the bandwidth gap link scheduler.
// Assumes gap exponents up to 7 (128 ms) and sub-queue counts up to 7 in the field.
package gls_pkg;
    localparam int GAP_SEL_W  = 3;
    localparam int GAP_CNT_W  = 8;
    localparam int SUBQ_CFG_W = 3;
    localparam int SEQ_W      = 8;

    // Gap length in milliseconds for a given exponent.
    function automatic logic [GAP_CNT_W-1:0] gap_len(input logic [GAP_SEL_W-1:0] sel);
        return GAP_CNT_W'(1) << sel;
    endfunction
endpackage

// File: rtl/gls_gap_timer.sv
// Per-link gap timer: after a restart, counts millisecond ticks and opens the
// gap once 2^sel ticks have been seen. Open at reset. Stays open until the next
// restart, so an idle link keeps its expired gap.
module gls_gap_timer
    import gls_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [GAP_SEL_W-1:0] sel,
    input  logic                 restart,
    output logic                 open
);
    logic [GAP_CNT_W-1:0] cnt;
    logic [GAP_CNT_W-1:0] cnt_nxt;

    // Next tick count.
    assign cnt_nxt = cnt + GAP_CNT_W'(1);

    // Count ticks since the last grant and open the gap at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            open <= 1'b1;
        end else if (restart) begin
            cnt  <= '0;
            open <= 1'b0;
        end else if (tick && !open) begin
            if (cnt_nxt == gap_len(sel)) begin
                cnt  <= '0;
                open <= 1'b1;
            end else begin
                cnt <= cnt_nxt;
            end
        end
    end
endmodule

// File: rtl/gls_subq_pick.sv
// Per-link sub-queue picker: finds the next non-empty active sub-queue in
// round-robin order starting after the last one served. Counts 0/1 mean a
// single queue; counts above MAX_SUBQ are clipped. Assumes adv is only
// raised in a cycle where any is high.
module gls_subq_pick
    import gls_pkg::*;
#(
    parameter int MAX_SUBQ = 4,
    parameter int QW       = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MAX_SUBQ-1:0]   ready,
    input  logic [SUBQ_CFG_W-1:0] cfg,
    input  logic                  adv,
    output logic                  any,
    output logic [QW-1:0]         pick
);
    logic [QW-1:0] ptr;
    int            nq;
    int            start;

    // Decode active queue count and search from the round-robin pointer.
    always_comb begin
        if (cfg < SUBQ_CFG_W'(2))            nq = 1;
        else if (int'(cfg) > MAX_SUBQ)       nq = MAX_SUBQ;
        else                                 nq = int'(cfg);
        start = (int'(ptr) >= nq) ? 0 : int'(ptr);
        any   = 1'b0;
        pick  = '0;
        for (int k = 0; k < MAX_SUBQ; k++) begin
            int idx;
            idx = start + k;
            if (idx >= nq) idx = idx - nq;
            if (k < nq) begin
                if (!any && ready[idx]) begin
                    any  = 1'b1;
                    pick = QW'(idx);
                end
            end
        end
    end

    // Move the pointer past the sub-queue just granted.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (adv)    ptr <= (int'(pick) + 1 >= nq) ? '0 : pick + QW'(1);
    end
endmodule

// File: rtl/gap_link_sched.sv
// Top of the bandwidth gap link scheduler. Each link owns a gap timer, a
// sub-queue picker and a sequence counter; a fixed-priority choice (lowest
// index first) raises one grant at a time, held until tx_done.
// Assumes configuration is static while grants are outstanding.
module gap_link_sched
    import gls_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int MAX_SUBQ  = 4,
    localparam int LW = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
    localparam int QW = (MAX_SUBQ > 1) ? $clog2(MAX_SUBQ) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ms_tick,
    input  logic [NUM_LINKS*GAP_SEL_W-1:0]  cfg_gap_sel,
    input  logic [NUM_LINKS*SUBQ_CFG_W-1:0] cfg_subq,
    input  logic [NUM_LINKS*MAX_SUBQ-1:0]   queue_ready,
    input  logic                            tx_done,
    output logic                            grant_valid,
    output logic [LW-1:0]                   grant_link,
    output logic [QW-1:0]                   grant_subq,
    output logic [SEQ_W-1:0]                grant_seq
);
    logic [NUM_LINKS-1:0] gap_open;
    logic [NUM_LINKS-1:0] has_frame;
    logic [NUM_LINKS-1:0] eligible;
    logic [NUM_LINKS-1:0] restart;
    logic [QW-1:0]        pick  [NUM_LINKS];
    logic [SEQ_W-1:0]     seq_r [NUM_LINKS];
    logic [LW-1:0]        win;
    logic                 launch;

    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
        gls_gap_timer u_gap (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (ms_tick),
            .sel     (cfg_gap_sel[l*GAP_SEL_W +: GAP_SEL_W]),
            .restart (restart[l]),
            .open    (gap_open[l])
        );

        gls_subq_pick #(.MAX_SUBQ(MAX_SUBQ), .QW(QW)) u_pick (
            .clk   (clk),
            .rst_n (rst_n),
            .ready (queue_ready[l*MAX_SUBQ +: MAX_SUBQ]),
            .cfg   (cfg_subq[l*SUBQ_CFG_W +: SUBQ_CFG_W]),
            .adv   (restart[l]),
            .any   (has_frame[l]),
            .pick  (pick[l])
        );

        // A link competes when its gap is open and it has a frame.
        assign eligible[l] = gap_open[l] & has_frame[l];
        // The winning link restarts its gap and advances its picker.
        assign restart[l]  = launch && (win == LW'(l));

        // Per-link sequence number: 0 first, then 1..255, wrapping to 1.
        always_ff @(posedge clk) begin
            if (!rst_n)           seq_r[l] <= '0;
            else if (restart[l])  seq_r[l] <= (seq_r[l] == '1) ? SEQ_W'(1) : seq_r[l] + SEQ_W'(1);
        end
    end

    // Lowest eligible link index wins.
    always_comb begin
        win = '0;
        for (int l = NUM_LINKS - 1; l >= 0; l--) begin
            if (eligible[l]) win = LW'(l);
        end
    end

    // A new grant is only raised while none is outstanding.
    assign launch = !grant_valid && (|eligible);

    // Grant register: capture on launch, release on tx_done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_link  <= '0;
            grant_subq  <= '0;
            grant_seq   <= '0;
        end else if (launch) begin
            grant_valid <= 1'b1;
            grant_link  <= win;
            grant_subq  <= pick[win];
            grant_seq   <= seq_r[win];
        end else if (grant_valid && tx_done) begin
            grant_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/gls_checker.sv
// Assertion checker for gap_link_sched, attached with bind. Watches grant
// holding, release, flag legality and sub-queue range.
module gls_checker
    import gls_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int MAX_SUBQ  = 4,
    parameter int LW        = 2,
    parameter int QW        = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            tx_done,
    input logic [NUM_LINKS*SUBQ_CFG_W-1:0] cfg_subq,
    input logic [NUM_LINKS*MAX_SUBQ-1:0]   queue_ready,
    input logic                            grant_valid,
    input logic [LW-1:0]                   grant_link,
    input logic [QW-1:0]                   grant_subq,
    input logic [SEQ_W-1:0]                grant_seq
);
    logic [NUM_LINKS*MAX_SUBQ-1:0] q_prev;
    logic [SUBQ_CFG_W-1:0]         cfg_g;
    int                            nq_g;

    // Remember the flags seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q_prev <= '0;
        else        q_prev <= queue_ready;
    end

    // Active queue count of the granted link.
    always_comb begin
        cfg_g = cfg_subq[int'(grant_link)*SUBQ_CFG_W +: SUBQ_CFG_W];
        if (cfg_g < SUBQ_CFG_W'(2))        nq_g = 1;
        else if (int'(cfg_g) > MAX_SUBQ)   nq_g = MAX_SUBQ;
        else                               nq_g = int'(cfg_g);
    end

    // R5
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !tx_done |=> grant_valid && $stable(grant_link)
                                    && $stable(grant_subq) && $stable(grant_seq));

    // R5
    grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && tx_done |=> !grant_valid);

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> q_prev[int'(grant_link)*MAX_SUBQ + int'(grant_subq)]);

    // R6
    subq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> int'(grant_subq) < nq_g);
endmodule

bind gap_link_sched gls_checker #(
    .NUM_LINKS (NUM_LINKS),
    .MAX_SUBQ  (MAX_SUBQ),
    .LW        (LW),
    .QW        (QW)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_done     (tx_done),
    .cfg_subq    (cfg_subq),
    .queue_ready (queue_ready),
    .grant_valid (grant_valid),
    .grant_link  (grant_link),
    .grant_subq  (grant_subq),
    .grant_seq   (grant_seq)
);

// File: tb/test_gap_link_sched.sv
`timescale 1ns/1ps
// Directed bench for gap_link_sched: one task per scenario, inputs driven and
// outputs sampled on the falling edge.
module test_gap_link_sched;
    localparam int NL = 4;
    localparam int MQ = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ms_tick;
    logic [NL*3-1:0]  cfg_gap_sel;
    logic [NL*3-1:0]  cfg_subq;
    logic [NL*MQ-1:0] queue_ready;
    logic          tx_done;
    logic          grant_valid;
    logic [1:0]    grant_link;
    logic [1:0]    grant_subq;
    logic [7:0]    grant_seq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gap_link_sched i_gap_link_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .ms_tick     (ms_tick),
        .cfg_gap_sel (cfg_gap_sel),
        .cfg_subq    (cfg_subq),
        .queue_ready (queue_ready),
        .tx_done     (tx_done),
        .grant_valid (grant_valid),
        .grant_link  (grant_link),
        .grant_subq  (grant_subq),
        .grant_seq   (grant_seq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        step();
        ms_tick = 1'b0;
    endtask

    task automatic done();
        tx_done = 1'b1;
        step();
        tx_done = 1'b0;
    endtask

    task automatic expect_grant(input string req, input int lk, input int sq, input int sn);
        chk(grant_valid == 1'b1, {req, " valid"}, int'(grant_valid), 1);
        chk(int'(grant_link) == lk, {req, " link"}, int'(grant_link), lk);
        chk(int'(grant_subq) == sq, {req, " subq"}, int'(grant_subq), sq);
        chk(int'(grant_seq) == sn, {req, " seq"}, int'(grant_seq), sn);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ms_tick = 1'b0; tx_done = 1'b0;
        cfg_gap_sel = '0; cfg_subq = '0; queue_ready = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    // R1 R2 R3: reset state, gap spacing, immediate grant after idle expiry.
    task automatic t_gap();
        do_reset();
        chk(grant_valid == 1'b0, "R1 reset idle", int'(grant_valid), 0);
        cfg_gap_sel[2:0] = 3'd2;           // 4 ms
        queue_ready[0] = 1'b1;
        step();
        expect_grant("R1 first grant", 0, 0, 0);
        done();
        repeat (3) tick();
        step();
        chk(grant_valid == 1'b0, "R2 gap not yet open", int'(grant_valid), 0);
        tick();                             // fourth tick opens the gap
        chk(grant_valid == 1'b0, "R2 open edge", int'(grant_valid), 0);
        step();
        expect_grant("R2 after gap", 0, 0, 1);
        done();
        queue_ready[0] = 1'b0;
        repeat (6) tick();
        repeat (3) step();
        chk(grant_valid == 1'b0, "R3 idle link", int'(grant_valid), 0);
        queue_ready[0] = 1'b1;
        step();
        expect_grant("R3 immediate", 0, 0, 2);
        done();
    endtask

    // R4 R5 R8: priority, hold until done, independent sequence per link.
    task automatic t_priority();
        do_reset();
        queue_ready[4]  = 1'b1;            // link1 q0
        queue_ready[12] = 1'b1;            // link3 q0
        step();
        expect_grant("R4 lowest link", 1, 0, 0);
        repeat (3) step();
        expect_grant("R5 held", 1, 0, 0);
        done();
        chk(grant_valid == 1'b0, "R5 released", int'(grant_valid), 0);
        step();
        expect_grant("R8 link3 own seq", 3, 0, 0);
        done();
    endtask

    // R6: three sub-queues round-robin, queue 3 flag ignored; then skipping.
    task automatic t_roundrobin();
        int exp3 [4] = '{0, 1, 2, 0};
        int exp4 [3] = '{0, 2, 0};
        do_reset();
        cfg_subq[8:6] = 3'd3;
        queue_ready[11:8] = 4'hF;
        step();
        for (int i = 0; i < 4; i++) begin
            expect_grant("R6 rr three", 2, exp3[i], i);
            done(); tick(); step();
        end
        done();
        do_reset();
        cfg_subq[2:0] = 3'd4;
        queue_ready[3:0] = 4'b0101;
        step();
        for (int i = 0; i < 3; i++) begin
            expect_grant("R6 rr skip", 0, exp4[i], i);
            done(); tick(); step();
        end
        done();
    endtask

    // R7 R9: sub-queues disabled, only queue 0 counts.
    task automatic t_disabled();
        do_reset();
        cfg_subq[5:3] = 3'd1;
        queue_ready[6:5] = 2'b11;           // link1 q1,q2
        repeat (3) step();
        chk(grant_valid == 1'b0, "R7 upper flags ignored", int'(grant_valid), 0);
        cfg_subq[5:3] = 3'd0;
        repeat (2) step();
        chk(grant_valid == 1'b0, "R9 no flag no grant", int'(grant_valid), 0);
        queue_ready[4] = 1'b1;
        step();
        expect_grant("R7 queue0 served", 1, 0, 0);
        done();
    endtask

    // R8: sequence wraps 255 -> 1.
    task automatic t_wrap();
        do_reset();
        queue_ready[0] = 1'b1;
        step();
        for (int n = 0; n < 258; n++) begin
            int e;
            e = (n == 0) ? 0 : ((n - 1) % 255) + 1;
            chk(grant_valid == 1'b1 && int'(grant_seq) == e, "R8 seq wrap",
                int'(grant_seq), e);
            done(); tick(); step();
        end
        done();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_gap();
        t_priority();
        t_roundrobin();
        t_disabled();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule